// File: doc/BRIEF.md
# Edge-Interrupt GPIO Register Block

An eight-line general-purpose I/O peripheral behind a byte-wide register bus. The four low lines drive fixed outputs from a latch. The four high lines are fixed inputs. Each input is brought into the clock domain by a two-flop synchronizer. A further flop holds the previous sample, so that rising and falling transitions can be found.

Software programs a 2-bit edge selector for each input line. The block records every selected edge in a sticky status bit. Writing a one to a status bit clears it. Because of this, software can read the status register and write the same value back to acknowledge exactly the events it saw. All pending status bits are ORed onto one level-sensitive interrupt line. Line direction is fixed in hardware, and the direction register always reads back the output mask.

Top module: `edge_gpio_top`

## Requirements
- R1: While reset is high and on the cycle after it, gpio_out, irq and rdata are zero. The edge-select register and the status register also start at zero.
- R2: A read of offset 0 (direction) returns 0x0F. Writes to offset 0 have no effect.
- R3: A write to offset 1 (data) loads wdata[3:0] into the output latch, which drives gpio_out from the next cycle. wdata[7:4] is ignored. A read of offset 1 returns the latch on bits [3:0] and the synchronized input lines on bits [7:4].
- R4: A level change on gpio_in passes through two synchronizer flops. The matching status bit is set on the third rising clock edge after the change, and not before.
- R5: Offset 3 (edge select) is read/write. Input n uses bits [2n+1:2n]. Within that field, bit 0 enables falling edges and bit 1 enables rising edges, so 11 selects both edges and 00 selects none. An edge that is not selected sets no status bit.
- R6: Offset 4 (status) bit n is set when a selected edge occurs on gpio_in[n]. Bits [7:4] read as zero.
- R7: Writing to offset 4 clears each status bit whose wdata bit is 1. Bits written with 0 are left unchanged.
- R8: If a new selected edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: irq is high exactly while any status bit is set. It remains high until the last set bit is cleared.
- R10: Offsets 2, 5, 6 and 7 read as zero. Writes to them change no state.
- R11: rdata is registered. It takes the addressed value on the clock edge where rd_en is high and holds that value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| gpio_in | input | 4 | Asynchronous input lines (GPIO 4..7) |
| gpio_out | output | 4 | Output latch (GPIO 0..3) |
| irq | output | 1 | Level interrupt, OR of pending status bits |

## Verification
The edge detector is driven with one line changing at a time, under an edge-select word that gives each input a different mode (rising only, falling only, both, none). A status bit that sets on the wrong line, or on an edge that was not selected, is therefore told apart from a correct one. The latency is probed by sampling irq one cycle before and on the cycle when the first event should land. This separates the intended two-flop synchronizer from a shorter or longer path. Clearing is exercised with partial masks, an all-zero mask, and a clear that coincides with a fresh edge on the same bit, which shows whether set or clear takes precedence. Data reads with different input levels confirm which bit positions carry the latch and which carry the synchronized inputs.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int NUM_OUT = 4;
    localparam int NUM_IN  = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int CFG_W   = 2 * NUM_IN;

    // register byte offsets; the bus decodes on these
    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR  = 3'd0,
        SEL_DATA = 3'd1,
        SEL_CFG  = 3'd3,
        SEL_STAT = 3'd4
    } reg_sel_e;

    // per-input edge selector: MSB rising, LSB falling
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_sel_t;

    function automatic logic [DATA_W-1:0] dir_word();
        return DATA_W'({NUM_OUT{1'b1}});
    endfunction
endpackage

// File: rtl/edge_gpio_sync.sv
module edge_gpio_sync #(
    parameter int WIDTH = gpio_edge_pkg::NUM_IN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_line
            logic meta_q, sync_q, prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    meta_q <= 1'b0;
                    sync_q <= 1'b0;
                    prev_q <= 1'b0;
                end else begin
                    meta_q <= pin_async[i];
                    sync_q <= meta_q;
                    prev_q <= sync_q;
                end
            end
            assign cur[i]  = sync_q;
            assign prev[i] = prev_q;
        end
    endgenerate
endmodule

// File: rtl/edge_gpio_detect.sv
module edge_gpio_detect
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = NUM_IN
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIDTH-1:0]      cur,
    input  logic [WIDTH-1:0]      prev,
    input  edge_sel_t [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0]      clr_mask,
    output logic [WIDTH-1:0]      pending
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic went_up, went_down, hit, pend_q;
            assign went_up   = cur[i] & ~prev[i];
            assign went_down = ~cur[i] & prev[i];
            assign hit       = (sel[i].rise & went_up) | (sel[i].fall & went_down);
            always_ff @(posedge clk) begin
                if (rst) pend_q <= 1'b0;
                else     pend_q <= hit | (pend_q & ~clr_mask[i]);
            end
            assign pending[i] = pend_q;
        end
    endgenerate
endmodule

// File: rtl/edge_gpio_regs.sv
module edge_gpio_regs
    import gpio_edge_pkg::*;
#(
    parameter int N_OUT = NUM_OUT,
    parameter int N_IN  = NUM_IN,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        addr,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DW-1:0]        wdata,
    input  logic [N_IN-1:0]      in_sync,
    input  logic [N_IN-1:0]      pending,
    output logic [N_OUT-1:0]     out_latch,
    output edge_sel_t [N_IN-1:0] sel,
    output logic [N_IN-1:0]      clr_mask,
    output logic [DW-1:0]        rdata
);
    localparam int SEL_W = 2 * N_IN;

    logic [N_OUT-1:0]     out_q;
    edge_sel_t [N_IN-1:0] sel_q;
    logic [DW-1:0]        rd_q;
    logic [DW-1:0]        rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            sel_q <= '0;
            rd_q  <= '0;
        end else begin
            if (wr_en && addr == SEL_DATA) out_q <= wdata[N_OUT-1:0];
            if (wr_en && addr == SEL_CFG)  sel_q <= wdata[SEL_W-1:0];
            if (rd_en)                     rd_q  <= rd_mux;
        end
    end

    always_comb begin
        case (addr)
            SEL_DIR:  rd_mux = dir_word();
            SEL_DATA: rd_mux = DW'({in_sync, out_q});
            SEL_CFG:  rd_mux = DW'(sel_q);
            SEL_STAT: rd_mux = DW'(pending);
            default:  rd_mux = '0;
        endcase
    end

    assign clr_mask  = (wr_en && addr == SEL_STAT) ? wdata[N_IN-1:0] : '0;
    assign out_latch = out_q;
    assign sel       = sel_q;
    assign rdata     = rd_q;
endmodule

// File: rtl/edge_gpio_top.sv
module edge_gpio_top
    import gpio_edge_pkg::*;
#(
    parameter int N_OUT = NUM_OUT,
    parameter int N_IN  = NUM_IN,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [N_IN-1:0]  gpio_in,
    output logic [N_OUT-1:0] gpio_out,
    output logic             irq
);
    logic [N_IN-1:0]      in_cur, in_prev, clr_mask, pending;
    edge_sel_t [N_IN-1:0] sel;

    edge_gpio_sync #(.WIDTH(N_IN)) sync_i (
        .clk(clk), .rst(rst), .pin_async(gpio_in), .cur(in_cur), .prev(in_prev)
    );

    edge_gpio_detect #(.WIDTH(N_IN)) detect_i (
        .clk(clk), .rst(rst), .cur(in_cur), .prev(in_prev),
        .sel(sel), .clr_mask(clr_mask), .pending(pending)
    );

    edge_gpio_regs #(.N_OUT(N_OUT), .N_IN(N_IN), .DW(DW), .AW(AW)) regs_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .in_sync(in_cur), .pending(pending),
        .out_latch(gpio_out), .sel(sel), .clr_mask(clr_mask), .rdata(rdata)
    );

    assign irq = |pending;
endmodule

// File: rtl/edge_gpio_checker.sv
module edge_gpio_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [3:0] gpio_out,
    input logic       irq
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (gpio_out == 4'h0 && !irq && rdata == 8'h00));

    assert_dir_readback_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 3'd0) |=> rdata == 8'h0F);

    assert_data_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd1) |=> gpio_out == $past(wdata[3:0]));

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == 3'd1) |=> $stable(gpio_out));

    assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (irq && !(wr_en && addr == 3'd4)) |=> irq);

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == 3'd2 || addr >= 3'd5)) |=> rdata == 8'h00);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));
endmodule

bind edge_gpio_top edge_gpio_checker chk_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gpio_out(gpio_out), .irq(irq)
);

// File: tb/edge_gpio_top_tb_top.sv
module edge_gpio_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] gpio_in = '0;
    logic [3:0] gpio_out;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q[$];
    string      req_q[$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    edge_gpio_top dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in),
        .gpio_out(gpio_out), .irq(irq)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // monitor: compares registered read data on the negedge after the read edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R11: unexpected read result %02h expected none", rdata);
            end else begin
                check(rdata, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; rd_en = 1'b1;
        exp_q.push_back(exp); req_q.push_back(req);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic drive_pins(input logic [3:0] v);
        @(negedge clk); gpio_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({7'b0, irq}, 8'h00, "R1 irq during reset");
        check({4'b0, gpio_out}, 8'h00, "R1 gpio_out during reset");
        rst = 1'b0;
        @(negedge clk);
        check(rdata, 8'h00, "R1 rdata after reset");
        rd(3'd3, 8'h00, "R1 edge select reset");
        rd(3'd4, 8'h00, "R1 status reset");

        rd(3'd0, 8'h0F, "R2 direction");
        wr(3'd0, 8'hAA);
        rd(3'd0, 8'h0F, "R2 direction after write");

        wr(3'd1, 8'hF5);
        check({4'b0, gpio_out}, 8'h05, "R3 gpio_out");
        rd(3'd1, 8'h05, "R3 data read, inputs low");

        drive_pins(4'b1010);
        rd(3'd1, 8'hA5, "R3 data read, inputs 1010");
        rd(3'd4, 8'h00, "R5 edges with select 00");
        check({7'b0, irq}, 8'h00, "R5 irq with select 00");

        // in0 rising, in1 falling, in2 both, in3 none
        wr(3'd3, 8'h36);
        rd(3'd3, 8'h36, "R5 edge select readback");

        // latency: change pin, irq must appear on the third edge
        @(negedge clk); gpio_in = 4'b1011;
        @(negedge clk);
        @(negedge clk);
        check({7'b0, irq}, 8'h00, "R4 irq not before third edge");
        @(negedge clk);
        check({7'b0, irq}, 8'h01, "R4 irq on third edge");
        rd(3'd4, 8'h01, "R6 in0 rising");

        drive_pins(4'b1001);
        rd(3'd4, 8'h03, "R6 in1 falling");
        drive_pins(4'b0001);
        rd(3'd4, 8'h03, "R5 in3 select 00 ignored");
        drive_pins(4'b0000);
        rd(3'd4, 8'h03, "R5 in0 falling not selected");

        wr(3'd4, 8'h01);
        rd(3'd4, 8'h02, "R7 partial clear");
        check({7'b0, irq}, 8'h01, "R9 irq held with one bit left");
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h02, "R7 zero mask leaves bits");
        wr(3'd4, 8'h02);
        rd(3'd4, 8'h00, "R7 full clear");
        check({7'b0, irq}, 8'h00, "R9 irq low after last clear");

        drive_pins(4'b0100);
        rd(3'd4, 8'h04, "R5 in2 both, rising");
        // falling edge on in2 lands on the same edge as the clear
        @(negedge clk); gpio_in = 4'b0000;
        @(negedge clk);
        @(negedge clk); addr = 3'd4; wdata = 8'h04; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        rd(3'd4, 8'h04, "R8 set wins over clear");
        check({7'b0, irq}, 8'h01, "R9 irq after collision");
        wr(3'd4, 8'hF0);
        rd(3'd4, 8'h04, "R6 upper status bits no effect");
        wr(3'd4, 8'h04);
        rd(3'd4, 8'h00, "R7 clear after collision");

        wr(3'd2, 8'hFF);
        wr(3'd6, 8'hFF);
        rd(3'd2, 8'h00, "R10 offset 2");
        rd(3'd5, 8'h00, "R10 offset 5");
        rd(3'd7, 8'h00, "R10 offset 7");
        rd(3'd1, 8'h05, "R10 data untouched");
        rd(3'd3, 8'h36, "R10 edge select untouched");

        rd(3'd0, 8'h0F, "R11 load");
        @(negedge clk); addr = 3'd1;
        repeat (2) @(negedge clk);
        check(rdata, 8'h0F, "R11 hold without rd_en");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule